// File: doc/BRIEF.md
# Gated Store Buffer with Group Commit

This block sits between a speculative execution core and a plain memory write port. Stores do not go to memory when they are issued. Each store carries an address, a data word and byte enables, and it enters a small queue in program order. The stores stay there, gated, until the core marks a commit point. The commit marker is the same group-commit event that checkpoints the register state, so memory and registers become coherent at the same boundary.

A commit releases every gated store, including a store accepted in the same cycle as the commit. The released stores then drain to the memory port in their original order, one per accepted cycle. If an exception forces a rollback, every store that has not been committed is discarded and never reaches memory. Stores that were committed earlier but have not yet drained are kept.

Loads can probe the buffer with a word address. The probe returns the youngest held store to that exact address, whether that store is committed or still speculative.

Top module: `gated_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_full`, `mem_wr_valid` and `ld_hit` are all 0.
- R2: A store is accepted on a clock edge when `st_valid`=1, `st_full`=0 and `grp_rollback`=0. An accepted store produces no memory write while it is uncommitted, whatever the value of `mem_wr_ready`.
- R3: A cycle with `grp_commit`=1 and `grp_rollback`=0 commits every held store, including a store accepted in that same cycle. `mem_wr_valid` is 1 from the next cycle on.
- R4: Committed stores leave through the memory port in program order. One store leaves on each cycle with `mem_wr_valid`=1 and `mem_wr_ready`=1. While `mem_wr_ready`=0, the port holds the same store.
- R5: A store accepted after a commit stays gated until a later commit. Once the committed group has drained, `mem_wr_valid` returns to 0 even though that store is still held.
- R6: A cycle with `grp_rollback`=1 discards every uncommitted store, including a store offered in that same cycle. Stores committed earlier still drain.
- R7: When `grp_commit` and `grp_rollback` are both 1 in the same cycle, the rollback takes precedence and nothing new is committed.
- R8: `st_full` is 1 when 16 stores (committed plus uncommitted) are held. A store offered while `st_full`=1 is ignored.
- R9: The lookup is combinational. `ld_hit`=1 when some held store has an address exactly equal to `ld_addr`. `ld_data` and `ld_be` then come from the youngest such store; on a miss they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered this cycle |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_full | output | 1 | Buffer holds its maximum number of stores |
| grp_commit | input | 1 | Group-commit marker |
| grp_rollback | input | 1 | Discard all uncommitted stores |
| mem_wr_valid | output | 1 | A committed store is presented to memory |
| mem_wr_ready | input | 1 | Memory accepts the presented store |
| mem_wr_addr | output | 32 | Address of the presented store |
| mem_wr_data | output | 32 | Data of the presented store |
| mem_wr_be | output | 4 | Byte enables of the presented store |
| ld_addr | input | 32 | Lookup word address |
| ld_hit | output | 1 | A held store matches the lookup address |
| ld_data | output | 32 | Data of the youngest matching store |
| ld_be | output | 4 | Byte enables of the youngest matching store |

## Verification
The assertions watch the pointer control on every cycle. They check that the occupancy never exceeds the capacity and that a commit or a rollback leaves no uncommitted store behind. They also check that the commit boundary moves only on a commit, and that a stalled memory port keeps its head store in place. Some properties need actual data to be observed: that each memory write carries the right payload in program order, that a store offered together with a rollback or while the buffer is full never appears, and that the youngest store wins a lookup. Only the bench's scenarios can show these, by comparing the ports against an independent queue model.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

  // Group action applied to the speculative region in one cycle.
  typedef enum logic [1:0] {
    GRP_HOLD    = 2'd0,
    GRP_COMMIT  = 2'd1,
    GRP_DISCARD = 2'd2
  } grp_op_e;

  // A rollback always takes precedence over a commit in the same cycle.
  function automatic grp_op_e resolve_op(input logic commit_i, input logic rollback_i);
    if (rollback_i) return GRP_DISCARD;
    if (commit_i)   return GRP_COMMIT;
    return GRP_HOLD;
  endfunction

  // Store acceptance rule: offered, room left, and not being discarded.
  function automatic logic store_accept(input logic valid_i, input logic full_i,
                                        input grp_op_e op_i);
    return valid_i && !full_i && (op_i != GRP_DISCARD);
  endfunction

endpackage

// File: rtl/gsb_ctrl.sv
module gsb_ctrl #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic          grp_commit,
  input  logic          grp_rollback,
  input  logic          mem_ready,
  output logic          push,
  output logic          pop,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] head_idx,
  output logic [PW-1:0] held_cnt,
  output logic          full,
  output logic          drain_valid
);
  import gsb_pkg::*;

  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  // Pointers carry a wrap bit: head = oldest, cmt = first uncommitted, tail = next free.
  logic [PW-1:0] head_q, cmt_q, tail_q;
  logic [PW-1:0] tail_adv;
  logic [PW-1:0] pend_cnt;
  grp_op_e       op;

  assign op          = resolve_op(grp_commit, grp_rollback);
  assign held_cnt    = tail_q - head_q;
  assign pend_cnt    = tail_q - cmt_q;
  assign full        = (held_cnt == CAP);
  assign drain_valid = (head_q != cmt_q);
  assign push        = store_accept(st_valid, full, op);
  assign pop         = drain_valid && mem_ready;
  assign wr_idx      = tail_q[IW-1:0];
  assign head_idx    = head_q[IW-1:0];
  assign tail_adv    = tail_q + PW'(push);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + PW'(pop);
      unique case (op)
        GRP_COMMIT: begin
          cmt_q  <= tail_adv;
          tail_q <= tail_adv;
        end
        GRP_DISCARD: tail_q <= cmt_q;
        default:     tail_q <= tail_adv;
      endcase
    end
  end

  // R8: occupancy never exceeds capacity
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    held_cnt <= CAP);

  // R3: a commit leaves nothing uncommitted
  a_r3_commit_seals: assert property (@(posedge clk) disable iff (!rst_n)
    (op == GRP_COMMIT) |=> (pend_cnt == '0));

  // R6: a rollback leaves nothing uncommitted and keeps the boundary
  a_r6_discard_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op == GRP_DISCARD) |=> (pend_cnt == '0) && $stable(cmt_q));

  // R5: without a commit the boundary does not move
  a_r5_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op != GRP_COMMIT) |=> $stable(cmt_q));

  // R4: a stalled port keeps its head store
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !mem_ready) |=> drain_valid && $stable(head_q));

endmodule

// File: rtl/gsb_store.sv
module gsb_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW = DW / 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [IW-1:0]              wr_idx,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [BW-1:0]              wr_be,
  input  logic [IW-1:0]              rd_idx,
  output logic [AW-1:0]              rd_addr,
  output logic [DW-1:0]              rd_data,
  output logic [BW-1:0]              rd_be,
  output logic [DEPTH-1:0][AW-1:0]   all_addr,
  output logic [DEPTH-1:0][DW-1:0]   all_data,
  output logic [DEPTH-1:0][BW-1:0]   all_be
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (wr_idx == IW'(g))) begin
        all_addr[g] <= wr_addr;
        all_data[g] <= wr_data;
        all_be[g]   <= wr_be;
      end
    end
  end

  assign rd_addr = all_addr[rd_idx];
  assign rd_data = all_data[rd_idx];
  assign rd_be   = all_be[rd_idx];

endmodule

// File: rtl/gsb_lookup.sv
module gsb_lookup #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW = DW / 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic [AW-1:0]              ld_addr,
  input  logic [IW-1:0]              head_idx,
  input  logic [PW-1:0]              held_cnt,
  input  logic [DEPTH-1:0][AW-1:0]   all_addr,
  input  logic [DEPTH-1:0][DW-1:0]   all_data,
  input  logic [DEPTH-1:0][BW-1:0]   all_be,
  output logic                       ld_hit,
  output logic [DW-1:0]              ld_data,
  output logic [BW-1:0]              ld_be
);

  logic [DEPTH-1:0][IW-1:0] age;
  logic [DEPTH-1:0]         match;

  // Age of a slot = distance from the oldest entry; live when inside the held range.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign age[g]   = IW'(g) - head_idx;
    assign match[g] = ({1'b0, age[g]} < held_cnt) && (all_addr[g] == ld_addr);
  end

  // Youngest match = largest age among the matching slots.
  always_comb begin
    logic [IW-1:0] best_age;
    ld_hit   = 1'b0;
    ld_data  = '0;
    ld_be    = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!ld_hit || age[i] > best_age)) begin
        ld_hit   = 1'b1;
        best_age = age[i];
        ld_data  = all_data[i];
        ld_be    = all_be[i];
      end
    end
  end

endmodule

// File: rtl/gated_store_buffer.sv
module gated_store_buffer #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW = DW / 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  output logic          st_full,
  input  logic          grp_commit,
  input  logic          grp_rollback,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic [BW-1:0] mem_wr_be,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic [BW-1:0] ld_be
);

  logic                     push, pop;
  logic [IW-1:0]            wr_idx, head_idx;
  logic [PW-1:0]            held_cnt;
  logic [DEPTH-1:0][AW-1:0] all_addr;
  logic [DEPTH-1:0][DW-1:0] all_data;
  logic [DEPTH-1:0][BW-1:0] all_be;

  gsb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .grp_commit  (grp_commit),
    .grp_rollback(grp_rollback),
    .mem_ready   (mem_wr_ready),
    .push        (push),
    .pop         (pop),
    .wr_idx      (wr_idx),
    .head_idx    (head_idx),
    .held_cnt    (held_cnt),
    .full        (st_full),
    .drain_valid (mem_wr_valid)
  );

  gsb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .we      (push),
    .wr_idx  (wr_idx),
    .wr_addr (st_addr),
    .wr_data (st_data),
    .wr_be   (st_be),
    .rd_idx  (head_idx),
    .rd_addr (mem_wr_addr),
    .rd_data (mem_wr_data),
    .rd_be   (mem_wr_be),
    .all_addr(all_addr),
    .all_data(all_data),
    .all_be  (all_be)
  );

  gsb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lookup (
    .ld_addr (ld_addr),
    .head_idx(head_idx),
    .held_cnt(held_cnt),
    .all_addr(all_addr),
    .all_data(all_data),
    .all_be  (all_be),
    .ld_hit  (ld_hit),
    .ld_data (ld_data),
    .ld_be   (ld_be)
  );

  // R9: a hit needs at least one held store
  a_r9_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> (held_cnt != '0));

  // R4: a pop only happens on a presented store
  a_r4_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> mem_wr_valid);

endmodule

// File: tb/test_gated_store_buffer.sv
module test_gated_store_buffer;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  b;
  } st_t;

  localparam int DEPTH = 16;
  localparam int NV = 6;
  // Stimulus vectors; entries 1 and 4 share an address (youngest-wins case).
  localparam st_t VEC [NV] = '{
    '{32'h0000_0100, 32'hA1A1_0001, 4'hF},
    '{32'h0000_0200, 32'hB2B2_0002, 4'h3},
    '{32'h0000_0300, 32'hC3C3_0003, 4'hC},
    '{32'h0000_0400, 32'hD4D4_0004, 4'h1},
    '{32'h0000_0200, 32'hE5E5_0005, 4'hF},
    '{32'h0000_0500, 32'hF6F6_0006, 4'h8}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, grp_commit, grp_rollback, mem_wr_ready;
  logic [31:0] st_addr, st_data, ld_addr;
  logic [3:0]  st_be;
  logic        st_full, mem_wr_valid, ld_hit;
  logic [31:0] mem_wr_addr, mem_wr_data, ld_data;
  logic [3:0]  mem_wr_be, ld_be;

  int n_chk = 0;
  int n_bad = 0;
  st_t exp_q[$];   // committed, not drained
  st_t pend_q[$];  // uncommitted

  always #10 clk = ~clk;

  gated_store_buffer i_gated_store_buffer (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_full(st_full),
    .grp_commit(grp_commit), .grp_rollback(grp_rollback),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // One clock with the given inputs; model updated by the requirement rules.
  task automatic cyc(input bit sv, input st_t s, input bit cm, input bit rb);
    st_valid = sv; st_addr = s.a; st_data = s.d; st_be = s.b;
    grp_commit = cm; grp_rollback = rb;
    if (rb) pend_q.delete();
    else if (sv && (exp_q.size() + pend_q.size() < DEPTH)) pend_q.push_back(s);
    if (cm && !rb) begin
      foreach (pend_q[k]) exp_q.push_back(pend_q[k]);
      pend_q.delete();
    end
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0; grp_commit = 1'b0; grp_rollback = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    bit          hit = 0;
    logic [35:0] e = '0;
    for (int k = pend_q.size() - 1; k >= 0 && !hit; k--)
      if (pend_q[k].a == a) begin hit = 1; e = {pend_q[k].d, pend_q[k].b}; end
    for (int k = exp_q.size() - 1; k >= 0 && !hit; k--)
      if (exp_q[k].a == a) begin hit = 1; e = {exp_q[k].d, exp_q[k].b}; end
    ld_addr = a;
    #1;
    check(ld_hit == hit, tag, 64'(ld_hit), 64'(hit));
    if (hit) check({ld_data, ld_be} == e, tag, 64'({ld_data, ld_be}), 64'(e));
  endtask

  // Drain all committed stores with the port ready; then the port must be idle.
  task automatic drain(input string tag);
    mem_wr_ready = 1'b1;
    while (exp_q.size() > 0) begin
      #1;
      check(mem_wr_valid && ({mem_wr_addr, mem_wr_data, mem_wr_be} == exp_q[0]),
            tag, 64'({mem_wr_valid, mem_wr_addr[27:0], mem_wr_data}),
            64'({1'b1, exp_q[0].a[27:0], exp_q[0].d}));
      void'(exp_q.pop_front());
      @(posedge clk);
      @(negedge clk);
    end
    #1;
    check(mem_wr_valid == 1'b0, tag, 64'(mem_wr_valid), 64'd0);
    mem_wr_ready = 1'b0;
    @(negedge clk);
  endtask

  localparam st_t NONE = '{32'h0, 32'h0, 4'h0};

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; grp_commit = 1'b0; grp_rollback = 1'b0;
    mem_wr_ready = 1'b0; st_addr = '0; st_data = '0; st_be = '0; ld_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(st_full == 1'b0, "R1 full", 64'(st_full), 64'd0);
    check(mem_wr_valid == 1'b0, "R1 mem valid", 64'(mem_wr_valid), 64'd0);
    lookup(32'h0, "R1 lookup");

    // R2 / R9: vector walk, stores gated even with the port ready
    mem_wr_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VEC[i], 1'b0, 1'b0);
      #1;
      check(mem_wr_valid == 1'b0, "R2 gated", 64'(mem_wr_valid), 64'd0);
      lookup(VEC[i].a, "R9 lookup");
    end
    mem_wr_ready = 1'b0;
    lookup(32'h0000_0200, "R9 youngest");

    // R3: commit together with a store includes that store
    cyc(1'b1, '{32'h0000_0600, 32'h1234_5678, 4'h6}, 1'b1, 1'b0);
    #1;
    check(mem_wr_valid == 1'b1, "R3 released", 64'(mem_wr_valid), 64'd1);
    // R4: stall holds head store
    check(mem_wr_addr == VEC[0].a, "R4 head", 64'(mem_wr_addr), 64'(VEC[0].a));
    cyc(1'b0, NONE, 1'b0, 1'b0);
    #1;
    check(mem_wr_valid && mem_wr_addr == VEC[0].a, "R4 stall",
          64'(mem_wr_addr), 64'(VEC[0].a));
    drain("R4 order");

    // R5: store after a commit stays gated
    cyc(1'b1, '{32'h0000_0700, 32'h7777_0007, 4'hF}, 1'b0, 1'b0);
    cyc(1'b0, NONE, 1'b1, 1'b0);
    cyc(1'b1, '{32'h0000_0800, 32'h8888_0008, 4'hF}, 1'b0, 1'b0);
    drain("R5 group");
    lookup(32'h0000_0800, "R5 still held");

    // R6: rollback drops held and same-cycle stores
    cyc(1'b1, '{32'h0000_0900, 32'h9999_0009, 4'hF}, 1'b0, 1'b1);
    #1;
    check(mem_wr_valid == 1'b0, "R6 nothing out", 64'(mem_wr_valid), 64'd0);
    lookup(32'h0000_0800, "R6 dropped old");
    lookup(32'h0000_0900, "R6 dropped new");
    // R6: committed store survives a later rollback
    cyc(1'b1, '{32'h0000_0A00, 32'hAAAA_000A, 4'h5}, 1'b1, 1'b0);
    cyc(1'b1, '{32'h0000_0B00, 32'hBBBB_000B, 4'hF}, 1'b0, 1'b0);
    cyc(1'b0, NONE, 1'b0, 1'b1);
    lookup(32'h0000_0B00, "R6 spec gone");
    drain("R6 committed kept");

    // R7: commit and rollback together -> rollback wins
    cyc(1'b1, '{32'h0000_0C00, 32'hCCCC_000C, 4'hF}, 1'b1, 1'b1);
    cyc(1'b1, '{32'h0000_0D00, 32'hDDDD_000D, 4'hF}, 1'b0, 1'b0);
    cyc(1'b0, NONE, 1'b1, 1'b1);
    #1;
    check(mem_wr_valid == 1'b0, "R7 no commit", 64'(mem_wr_valid), 64'd0);
    lookup(32'h0000_0C00, "R7 dropped C");
    lookup(32'h0000_0D00, "R7 dropped D");

    // R8: fill to capacity, extra store ignored
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      check(st_full == 1'b0, "R8 not full", 64'(st_full), 64'd0);
      cyc(1'b1, '{32'h0000_1000 + 32'(i * 4), 32'h5000_0000 + 32'(i), 4'(i)}, 1'b0, 1'b0);
    end
    #1;
    check(st_full == 1'b1, "R8 full", 64'(st_full), 64'd1);
    cyc(1'b1, '{32'h0000_2000, 32'hDEAD_BEEF, 4'hF}, 1'b0, 1'b0);
    lookup(32'h0000_2000, "R8 ignored");
    cyc(1'b0, NONE, 1'b1, 1'b0);
    lookup(32'h0000_1000, "R9 committed hit");
    drain("R8 drain");

    finish_run();
  end

endmodule